// File: doc/BRIEF.md
# Adjustable Nanosecond Time-of-Day Clock

This block keeps a free-running time of day in whole nanoseconds. On every cycle of its fixed-rate clock it adds a constant base step, 8 ns by default, which software cannot change. The rate is trimmed by a signed fractional correction. The correction's magnitude is added into a 32-bit sub-nanosecond accumulator on every tick. Each carry out of that accumulator lengthens or shortens that tick's step by one nanosecond, and the sign chosen by software decides which. A correction of p parts per billion corresponds to a magnitude of p·2^26/1953125.

Software reaches the clock through a small 32-bit register port with single-cycle read and write strobes. Reading the residue word returns the accumulator. The same read freezes the whole nanosecond count into shadow storage, so the low and high words read afterwards belong to one instant. To set the time, software writes the low word first and then the high word. The full value loads in one step when the high word is written. The live count is also driven out for use by timestamping logic nearby.

Top module: `tod_clock`

## Requirements
- R1: After reset the count, the accumulator and the correction word are zero and the clock is halted: the control word (address 4) reads 0x8000_0000, and the correction (address 3) and residue (address 0) words read zero.
- R2: While bit 31 of the control word is set, the count does not change. Writing 0 to the control word starts counting on the following cycle.
- R3: While running with a zero correction magnitude, the count rises by exactly 8 per cycle.
- R4: While running, the magnitude in correction bits 30:0 is added to the 32-bit accumulator each cycle, modulo 2^32. When that sum carries out and correction bit 31 is 0, that cycle's step is 9.
- R5: When the sum carries out and correction bit 31 is 1, that cycle's step is 7.
- R6: A read of the residue word (address 0) returns the accumulator and captures the count. Later reads of the low word (address 1) return captured bits 31:0. Later reads of the high word (address 2) return captured bits 39:32 in bits 7:0, with bits 31:8 zero.
- R7: A read of the low or high word that no residue read precedes returns the last capture, not the live count.
- R8: A write to the low word alone leaves the count unchanged. A following write to the high word loads {high[7:0], low} into the count and clears the accumulator.
- R9: When a high-word write and a counting tick fall in the same cycle, the loaded value is taken and no step is added in that cycle.
- R10: The correction and control words read back the last value written to them. Read data appears one cycle after the read strobe and holds until the next read.
- R11: A write to the residue word sets the accumulator to the written value. The next tick's carry comes from that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-rate clock, one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe for the word at bus_addr |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 3 | Word select: 0 residue, 1 low, 2 high, 3 correction, 4 control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tod_ns | output | 40 | Live nanosecond count |

## Verification
Two pairs of functions can land on the same clock edge. A high-word load can coincide with a counting tick. A residue-word write can coincide with the carry that the old accumulator produces. Directed steps place a high-word write while the clock runs and expect the loaded value, with no step, at the next sample. They also place a residue write between two known ticks and expect a 9 ns step at the boundary that follows. The random phase issues reads and writes in the same cycle and loads while running. Every cycle it compares the count and the read data with a bench model built from the requirements.

// File: rtl/tod_pkg.sv
package tod_pkg;
   // Word select on the register port
   typedef enum logic [2:0] {
      REG_RESID = 3'd0,
      REG_LOW   = 3'd1,
      REG_HIGH  = 3'd2,
      REG_RATE  = 3'd3,
      REG_CTRL  = 3'd4
   } tod_reg_e;
endpackage

// File: rtl/tod_rate_accum.sv
module tod_rate_accum #(
   parameter int unsigned FRAC_W = 32,
   parameter bit          ADJ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              run_i,
   input  logic              clr_i,
   input  logic              set_i,
   input  logic [FRAC_W-1:0] set_val_i,
   input  logic [FRAC_W-1:0] rate_i,
   output logic [FRAC_W-1:0] acc_o,
   output logic              carry_o,
   output logic              neg_o
);
   localparam int unsigned MAG_W = FRAC_W - 1;

   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum_c;

   generate
      if (FRAC_W < 2) begin : g_bad_frac
         $error("tod_rate_accum: FRAC_W must be at least 2");
      end
      if (ADJ_EN) begin : g_adj
         assign sum_c   = {1'b0, acc_q} + {2'b0, rate_i[MAG_W-1:0]};
         assign neg_o   = rate_i[FRAC_W-1];
      end else begin : g_fixed
         assign sum_c   = {1'b0, acc_q};
         assign neg_o   = 1'b0;
      end
   endgenerate

   assign carry_o = sum_c[FRAC_W];
   assign acc_o   = acc_q;

   always_ff @(posedge clk) begin
      if (rst)        acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (set_i) acc_q <= set_val_i;
      else if (run_i) acc_q <= sum_c[FRAC_W-1:0];
   end

   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> acc_q == '0); // R8
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!run_i && !clr_i && !set_i) |=> $stable(acc_q)); // R2
   AST_ACC_SET: assert property (@(posedge clk) disable iff (rst)
      (set_i && !clr_i) |=> acc_q == $past(set_val_i)); // R11
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
   parameter int unsigned NS_W      = 40,
   parameter int unsigned BASE_STEP = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            run_i,
   input  logic            load_i,
   input  logic [NS_W-1:0] load_val_i,
   input  logic            carry_i,
   input  logic            neg_i,
   output logic [NS_W-1:0] ns_o
);
   localparam logic [NS_W-1:0] STEP_NOM  = NS_W'(BASE_STEP);
   localparam logic [NS_W-1:0] STEP_LONG = NS_W'(BASE_STEP + 1);
   localparam logic [NS_W-1:0] STEP_SHRT = NS_W'(BASE_STEP - 1);

   logic [NS_W-1:0] ns_q;
   logic [NS_W-1:0] step_c;

   generate
      if (BASE_STEP < 2 || BASE_STEP > 65535) begin : g_bad_step
         $error("tod_ns_counter: BASE_STEP out of range");
      end
   endgenerate

   always_comb begin
      step_c = STEP_NOM;
      if (carry_i) step_c = neg_i ? STEP_SHRT : STEP_LONG;
   end

   always_ff @(posedge clk) begin
      if (rst)         ns_q <= '0;
      else if (load_i) ns_q <= load_val_i;
      else if (run_i)  ns_q <= ns_q + step_c;
   end

   assign ns_o = ns_q;

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!run_i && !load_i) |=> $stable(ns_q)); // R2
   AST_STEP_NOM: assert property (@(posedge clk) disable iff (rst)
      (run_i && !load_i && !carry_i) |=> ns_q == $past(ns_q) + STEP_NOM); // R3
   AST_STEP_LONG: assert property (@(posedge clk) disable iff (rst)
      (run_i && !load_i && carry_i && !neg_i) |=> ns_q == $past(ns_q) + STEP_LONG); // R4
   AST_STEP_SHORT: assert property (@(posedge clk) disable iff (rst)
      (run_i && !load_i && carry_i && neg_i) |=> ns_q == $past(ns_q) + STEP_SHRT); // R5
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
      load_i |=> ns_q == $past(load_val_i)); // R9
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot #(
   parameter int unsigned NS_W = 40
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            snap_i,
   input  logic [NS_W-1:0] ns_i,
   output logic [NS_W-1:0] shadow_o
);
   logic [NS_W-1:0] shadow_q;

   always_ff @(posedge clk) begin
      if (rst)         shadow_q <= '0;
      else if (snap_i) shadow_q <= ns_i;
   end

   assign shadow_o = shadow_q;

   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (rst)
      snap_i |=> shadow_q == $past(ns_i)); // R6
   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
      !snap_i |=> $stable(shadow_q)); // R7
endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter int unsigned NS_W      = 40,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE_STEP = 8,
   parameter bit          ADJ_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NS_W-1:0]   tod_ns
);
   localparam int unsigned HI_W   = NS_W - DATA_W;
   localparam int unsigned FRAC_W = DATA_W;
   localparam int unsigned HALT_B = DATA_W - 1;

   generate
      if (NS_W <= DATA_W || NS_W >= 2 * DATA_W) begin : g_bad_ns
         $error("tod_clock: NS_W must lie strictly between DATA_W and 2*DATA_W");
      end
   endgenerate

   logic [FRAC_W-1:0] rate_q;
   logic              halt_q;
   logic [DATA_W-1:0] pend_lo_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] rd_val_c;
   logic [FRAC_W-1:0] acc_w;
   logic              carry_w;
   logic              neg_w;
   logic [NS_W-1:0]   ns_w;
   logic [NS_W-1:0]   shadow_w;

   logic wr_resid, wr_low, wr_high, wr_rate, wr_ctrl, rd_resid, run_w;

   assign wr_resid = bus_wr && (bus_addr == REG_RESID);
   assign wr_low   = bus_wr && (bus_addr == REG_LOW);
   assign wr_high  = bus_wr && (bus_addr == REG_HIGH);
   assign wr_rate  = bus_wr && (bus_addr == REG_RATE);
   assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
   assign rd_resid = bus_rd && (bus_addr == REG_RESID);
   assign run_w    = !halt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rate_q    <= '0;
         halt_q    <= 1'b1;
         pend_lo_q <= '0;
      end else begin
         if (wr_rate) rate_q    <= bus_wdata;
         if (wr_ctrl) halt_q    <= bus_wdata[HALT_B];
         if (wr_low)  pend_lo_q <= bus_wdata;
      end
   end

   tod_rate_accum #(.FRAC_W(FRAC_W), .ADJ_EN(ADJ_EN)) u_accum (
      .clk       (clk),
      .rst       (rst),
      .run_i     (run_w),
      .clr_i     (wr_high),
      .set_i     (wr_resid),
      .set_val_i (bus_wdata),
      .rate_i    (rate_q),
      .acc_o     (acc_w),
      .carry_o   (carry_w),
      .neg_o     (neg_w)
   );

   tod_ns_counter #(.NS_W(NS_W), .BASE_STEP(BASE_STEP)) u_count (
      .clk        (clk),
      .rst        (rst),
      .run_i      (run_w),
      .load_i     (wr_high),
      .load_val_i ({bus_wdata[HI_W-1:0], pend_lo_q}),
      .carry_i    (carry_w),
      .neg_i      (neg_w),
      .ns_o       (ns_w)
   );

   tod_snapshot #(.NS_W(NS_W)) u_snap (
      .clk      (clk),
      .rst      (rst),
      .snap_i   (rd_resid),
      .ns_i     (ns_w),
      .shadow_o (shadow_w)
   );

   always_comb begin
      case (tod_reg_e'(bus_addr))
         REG_RESID: rd_val_c = acc_w;
         REG_LOW:   rd_val_c = shadow_w[DATA_W-1:0];
         REG_HIGH:  rd_val_c = DATA_W'(shadow_w[NS_W-1:DATA_W]);
         REG_RATE:  rd_val_c = rate_q;
         REG_CTRL:  rd_val_c = {halt_q, {(DATA_W-1){1'b0}}};
         default:   rd_val_c = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_val_c;
   end

   assign bus_rdata = rdata_q;
   assign tod_ns    = ns_w;

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && bus_addr == REG_HIGH) |=> bus_rdata[DATA_W-1:HI_W] == '0); // R6
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
      !bus_rd |=> $stable(bus_rdata)); // R10
   AST_LOW_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
      (wr_low && !wr_high && halt_q) |=> $stable(tod_ns)); // R8
endmodule

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic [39:0] tod_ns;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   tod_clock u_dut (
      .clk       (clk),
      .rst       (rst),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tod_ns    (tod_ns)
   );

   // Reference model built from the requirements
   logic [39:0] m_ns, m_shadow, t_step;
   logic [31:0] m_acc, m_rate, m_pend, m_rdata;
   logic        m_halt;
   logic [32:0] t_sum;

   always @(posedge clk) begin
      if (rst) begin
         m_ns <= '0; m_shadow <= '0; m_acc <= '0; m_rate <= '0;
         m_pend <= '0; m_rdata <= '0; m_halt <= 1'b1;
      end else begin
         t_sum  = {1'b0, m_acc} + {2'b0, m_rate[30:0]};
         t_step = 40'd8;
         if (t_sum[32]) t_step = m_rate[31] ? 40'd7 : 40'd9;
         if (bus_rd) begin
            case (bus_addr)
               3'd0: m_rdata <= m_acc;
               3'd1: m_rdata <= m_shadow[31:0];
               3'd2: m_rdata <= {24'h0, m_shadow[39:32]};
               3'd3: m_rdata <= m_rate;
               3'd4: m_rdata <= {m_halt, 31'h0};
               default: m_rdata <= '0;
            endcase
            if (bus_addr == 3'd0) m_shadow <= m_ns;
         end
         if (bus_wr && bus_addr == 3'd2) begin
            m_ns  <= {bus_wdata[7:0], m_pend};
            m_acc <= '0;
         end else begin
            if (!m_halt) m_ns <= m_ns + t_step;
            if (bus_wr && bus_addr == 3'd0) m_acc <= bus_wdata;
            else if (!m_halt)               m_acc <= t_sum[31:0];
         end
         if (bus_wr && bus_addr == 3'd1) m_pend <= bus_wdata;
         if (bus_wr && bus_addr == 3'd3) m_rate <= bus_wdata;
         if (bus_wr && bus_addr == 3'd4) m_halt <= bus_wdata[31];
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // One clock: inputs already driven; sample after the falling edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      if (!rst) begin
         chk("R3 R4 R5 R9 live count vs model", {24'h0, tod_ns}, {24'h0, m_ns});
         chk("R6 R7 R10 R11 read data vs model", {32'h0, bus_rdata}, {32'h0, m_rdata});
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   task automatic rd(input logic [2:0] a);
      bus_addr = a; bus_rd = 1'b1; cyc();
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cyc();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [39:0] t0, snap;
      void'($urandom(32'd20240517));
      idle(3);
      rst = 1'b0;
      idle(1);
      chk("R1 count after reset", {24'h0, tod_ns}, 64'h0);
      rd(3'd4); chk("R1 control reads halted", {32'h0, bus_rdata}, 64'h8000_0000);
      rd(3'd3); chk("R1 correction zero", {32'h0, bus_rdata}, 64'h0);
      rd(3'd0); chk("R1 residue zero", {32'h0, bus_rdata}, 64'h0);
      idle(5);  chk("R2 halted count holds", {24'h0, tod_ns}, 64'h0);

      wr(3'd4, 32'h0);
      t0 = tod_ns; idle(10);
      chk("R3 ten nominal steps", {24'h0, tod_ns}, {24'h0, t0 + 40'd80});

      wr(3'd3, 32'h4000_0000);
      t0 = tod_ns; idle(4);
      chk("R4 positive carry step", {24'h0, tod_ns}, {24'h0, t0 + 40'd33});

      wr(3'd3, 32'hC000_0000);
      t0 = tod_ns; idle(3);
      chk("R5 negative carry step", {24'h0, tod_ns}, {24'h0, t0 + 40'd23});
      rd(3'd0); chk("R6 residue after wrap", {32'h0, bus_rdata}, 64'h0);

      idle(3);
      snap = tod_ns;
      rd(3'd0);
      rd(3'd1); chk("R6 low word of capture", {32'h0, bus_rdata}, {32'h0, snap[31:0]});
      rd(3'd2); chk("R6 high word of capture", {32'h0, bus_rdata}, {56'h0, snap[39:32]});
      idle(7);
      rd(3'd2); chk("R7 high word stale capture", {32'h0, bus_rdata}, {56'h0, snap[39:32]});
      rd(3'd1); chk("R7 low word stale capture", {32'h0, bus_rdata}, {32'h0, snap[31:0]});

      wr(3'd3, 32'h8000_0000);
      rd(3'd3); chk("R10 correction readback", {32'h0, bus_rdata}, 64'h8000_0000);
      rd(3'd4); chk("R10 control readback", {32'h0, bus_rdata}, 64'h0);
      wr(3'd0, 32'h0);

      wr(3'd3, 32'h1000_0000);
      wr(3'd0, 32'hF000_0000);
      t0 = tod_ns; cyc();
      chk("R11 carry from written residue", {24'h0, tod_ns}, {24'h0, t0 + 40'd9});
      rd(3'd0); chk("R11 residue after carry", {32'h0, bus_rdata}, 64'h0);
      wr(3'd3, 32'h8000_0000);
      wr(3'd0, 32'h0);

      wr(3'd1, 32'hDEAD_BEEF);
      t0 = tod_ns; idle(2);
      chk("R8 low write alone no load", {24'h0, tod_ns}, {24'h0, t0 + 40'd16});
      wr(3'd2, 32'h1234_56AB);
      chk("R9 load wins over tick", {24'h0, tod_ns}, 64'hAB_DEAD_BEEF);
      idle(1);
      chk("R8 counting resumes from load", {24'h0, tod_ns}, 64'hAB_DEAD_BEF7);

      wr(3'd4, 32'h8000_0000);
      t0 = tod_ns; idle(5);
      chk("R2 halt again holds", {24'h0, tod_ns}, {24'h0, t0});

      // Constrained random phase, checked every cycle against the model
      wr(3'd4, 32'h0);
      for (int k = 0; k < 4000; k++) begin
         int op;
         op = int'($urandom % 16);
         case (op)
            8:  rd(3'($urandom % 8));
            9:  wr(3'd3, {1'($urandom), 31'($urandom % 32'h7FFF_FFFF)});
            10: wr(3'd1, $urandom);
            11: wr(3'd2, $urandom);
            12: wr(3'd0, $urandom);
            13: wr(3'd4, ($urandom % 8 == 0) ? 32'h8000_0000 : 32'h0);
            14: begin
               bus_addr = 3'($urandom % 5); bus_wdata = $urandom;
               bus_rd = 1'b1; bus_wr = 1'b1; cyc();
            end
            15: begin rd(3'd0); rd(3'd1); rd(3'd2); end
            default: idle(1);
         endcase
      end
      summary();
      $finish;
   end
endmodule